// File: doc/BRIEF.md
# DMA completion status classifier

The block walks a ring of completion entries written by a DMA engine and decides what happens to each finished command. Every ring word holds a status byte, a command tag and a 16-bit sequence count. The block reads the slot at its current ring index through a simple read port. It treats the word as a new completion only when the count matches the sequence number it expects next. For each accepted entry it looks up the opcode that was recorded for the tag when the command was issued. It then does one of two things. It either retires the command with a 3-bit result code, or it hands the command back for reissue as a reconstructing read, ahead of any newer work.

Whoever issues commands records each one with a one-cycle `issue_vld` strobe that carries the tag and the opcode. The block frees that record when it accepts the completion. The block also keeps counters for each error bit and for each failure class. If a completion names a tag with no live record, the block stops reading the ring for good and raises a sticky protocol-error flag.

Top module: `cpl_sorter`

## Requirements
- R1: A ring word is accepted only when its count field (bits 31:16) equals the expected sequence number, which is 0 after reset. Each accepted word raises exactly one strobe, either done or retry, and advances both the expected number and the ring index by one. A word whose count does not match is re-read until it does match, and it produces no strobe.
- R2: The ring index counts modulo RING_DEPTH, a power of two. The bench's ring therefore wraps back to slot 0 after the last slot.
- R3: Ring word layout is: status in bits 7:0, tag in bits 15:8, count in bits 31:16. The status bits are: CRC error 0x01, hard error 0x02, soft error 0x04, fault 0x08. The result code bits are: bit0 software error, bit1 hardware fault, bit2 cancelled (never set by this block). A status of zero retires any command with result 000.
- R4: A read (opcode 0xC0) whose status has the CRC or hard-error bit set, while scrub_en is 1, is not retired. Instead it raises retry_vld with its tag and retry_op = 0xE0.
- R5: A read with the CRC or hard-error bit set while scrub_en is 0 retires with result 010. So does a read with only the fault bit set among CRC, hard error and fault. A read with only the soft bit set retires with 000.
- R6: A reconstructing read (opcode 0xE0) with the CRC or hard-error bit set retires with 010 and never raises a retry. Any other status on it retires with 000.
- R7: A write (0x80) or a discard (0x70) with any nonzero status retires with 010.
- R8: Any other opcode retires with 001 when the status is nonzero, and with 000 when the status is zero.
- R9: The CRC, hard and soft counters each increase by one for every accepted word that has their bit set, whatever the opcode.
- R10: Separate counters count retired reads that failed (opcodes 0xC0 and 0xE0 with result 010), failed writes, failed discards and issued retries.
- R11: A word with a matching count whose tag is out of range, was never recorded, or has already completed sets proto_err. proto_err stays set until reset. After that the block reads nothing more, raises no strobe and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Allow failed reads to be retried as reconstructing reads |
| issue_vld | input | 1 | Record a command against a tag |
| issue_tag | input | 8 | Tag being recorded |
| issue_op | input | 8 | Opcode of the recorded command |
| ring_rd | output | 1 | Read enable into the ring memory |
| ring_addr | output | $clog2(RING_DEPTH) | Ring slot being read |
| ring_data | input | 32 | Ring word, valid the cycle after ring_rd |
| done_vld | output | 1 | A command is retired |
| done_tag | output | 8 | Tag of the retired command |
| done_res | output | 3 | Result code |
| retry_vld | output | 1 | A command is to be reissued at the head of the queue |
| retry_tag | output | 8 | Tag the retried command held |
| retry_op | output | 8 | Opcode for the reissue |
| proto_err | output | 1 | Sticky: a completion named an unrecorded tag |
| cnt_crc | output | CNT_W | CRC error count |
| cnt_hard | output | CNT_W | Hard error count |
| cnt_soft | output | CNT_W | Soft error count |
| cnt_rd_fail | output | CNT_W | Failed reads |
| cnt_wr_fail | output | CNT_W | Failed writes |
| cnt_dis_fail | output | CNT_W | Failed discards |
| cnt_retry | output | CNT_W | Retries issued |

## Verification
Suppose the expected sequence number or the ring index goes wrong. The next completion is then never accepted, or a stale slot is taken again, so the strobe stream stops or repeats within a few cycles of the bad step. A wrong tag record shows up as the wrong result code, a retry where a retirement was due, or an early proto_err on the very next completion for that tag. A counter that misses or doubles an increment shows up when the counters are compared after each drained batch.

// File: rtl/cpl_sorter.sv
module cpl_sorter #(
  parameter int RING_DEPTH = 16,
  parameter int NTAGS      = 16,
  parameter int CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scrub_en,
  input  logic                          issue_vld,
  input  logic [7:0]                    issue_tag,
  input  logic [7:0]                    issue_op,
  output logic                          ring_rd,
  output logic [$clog2(RING_DEPTH)-1:0] ring_addr,
  input  logic [31:0]                   ring_data,
  output logic                          done_vld,
  output logic [7:0]                    done_tag,
  output logic [2:0]                    done_res,
  output logic                          retry_vld,
  output logic [7:0]                    retry_tag,
  output logic [7:0]                    retry_op,
  output logic                          proto_err,
  output logic [CNT_W-1:0]              cnt_crc,
  output logic [CNT_W-1:0]              cnt_hard,
  output logic [CNT_W-1:0]              cnt_soft,
  output logic [CNT_W-1:0]              cnt_rd_fail,
  output logic [CNT_W-1:0]              cnt_wr_fail,
  output logic [CNT_W-1:0]              cnt_dis_fail,
  output logic [CNT_W-1:0]              cnt_retry
);
  localparam int IDX_W = $clog2(RING_DEPTH);
  localparam int TAG_W = $clog2(NTAGS);
  localparam logic [7:0] OP_DIS = 8'h70;
  localparam logic [7:0] OP_WR  = 8'h80;
  localparam logic [7:0] OP_RD  = 8'hC0;
  localparam logic [7:0] OP_RCN = 8'hE0;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic             phase;
  logic [IDX_W-1:0] idx;
  logic [15:0]      exp_cnt;
  logic [7:0]       op_tab [NTAGS];
  logic [NTAGS-1:0] rec_vld;

  logic [7:0]       st, tg, op;
  logic [15:0]      seq;
  logic [TAG_W-1:0] ti, it;
  logic             hit, tag_ok, take, issue_ok, bad;
  logic             want_retry, f_rd, f_wr, f_dis;
  logic [2:0]       res;

  assign st       = ring_data[7:0];
  assign tg       = ring_data[15:8];
  assign seq      = ring_data[31:16];
  assign ti       = tg[TAG_W-1:0];
  assign it       = issue_tag[TAG_W-1:0];
  assign issue_ok = issue_vld && ((issue_tag >> TAG_W) == 8'd0);
  assign tag_ok   = ((tg >> TAG_W) == 8'd0) && rec_vld[ti];
  assign op       = op_tab[ti];
  assign hit      = phase && !proto_err && (seq == exp_cnt);
  assign take     = hit && tag_ok;
  assign bad      = st[0] | st[1];

  assign ring_rd   = !phase && !proto_err;
  assign ring_addr = idx;
  assign retry_op  = OP_RCN;

  always_comb begin
    res        = 3'b000;
    want_retry = 1'b0;
    f_rd       = 1'b0;
    f_wr       = 1'b0;
    f_dis      = 1'b0;
    case (op)
      OP_RD: begin
        if (bad && scrub_en) want_retry = 1'b1;
        else if (bad || st[3]) begin res = 3'b010; f_rd = 1'b1; end
      end
      OP_RCN: if (bad) begin res = 3'b010; f_rd = 1'b1; end
      OP_WR:  if (st != 8'd0) begin res = 3'b010; f_wr = 1'b1; end
      OP_DIS: if (st != 8'd0) begin res = 3'b010; f_dis = 1'b1; end
      default: if (st != 8'd0) res = 3'b001;
    endcase
  end

  always_ff @(posedge clk) begin
    if (issue_ok) op_tab[it] <= issue_op;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= 1'b0;
      idx          <= '0;
      exp_cnt      <= 16'd0;
      rec_vld      <= '0;
      proto_err    <= 1'b0;
      done_vld     <= 1'b0;
      done_tag     <= 8'd0;
      done_res     <= 3'b000;
      retry_vld    <= 1'b0;
      retry_tag    <= 8'd0;
      cnt_crc      <= '0;
      cnt_hard     <= '0;
      cnt_soft     <= '0;
      cnt_rd_fail  <= '0;
      cnt_wr_fail  <= '0;
      cnt_dis_fail <= '0;
      cnt_retry    <= '0;
    end else begin
      done_vld  <= 1'b0;
      retry_vld <= 1'b0;
      if (!proto_err) phase <= !phase;
      if (hit && !tag_ok) proto_err <= 1'b1;
      if (take) begin
        idx          <= idx + IDX_W'(1);
        exp_cnt      <= exp_cnt + 16'd1;
        rec_vld[ti]  <= 1'b0;
        done_vld     <= !want_retry;
        retry_vld    <= want_retry;
        done_tag     <= tg;
        retry_tag    <= tg;
        done_res     <= res;
        if (st[0])      cnt_crc      <= cnt_crc + ONE;
        if (st[1])      cnt_hard     <= cnt_hard + ONE;
        if (st[2])      cnt_soft     <= cnt_soft + ONE;
        if (f_rd)       cnt_rd_fail  <= cnt_rd_fail + ONE;
        if (f_wr)       cnt_wr_fail  <= cnt_wr_fail + ONE;
        if (f_dis)      cnt_dis_fail <= cnt_dis_fail + ONE;
        if (want_retry) cnt_retry    <= cnt_retry + ONE;
      end
      if (issue_ok) rec_vld[it] <= 1'b1;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld || retry_vld) |-> exp_cnt == $past(exp_cnt) + 16'd1); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> idx == $past(idx) + IDX_W'(1)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_vld && retry_vld)); // R1
  AST_RETRY_SCRUB: assert property (@(posedge clk) disable iff (!rst_n)
    retry_vld |-> $past(scrub_en)); // R4
  AST_SW_NOT_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_res[0]) |-> !done_res[1]); // R8
  AST_CRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_crc != $past(cnt_crc)) |-> cnt_crc == $past(cnt_crc) + ONE); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> (!done_vld && !retry_vld && !ring_rd)); // R11
endmodule

// File: tb/cpl_sorter_tb_top.sv
module cpl_sorter_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scrub_en = 1'b0;
  logic issue_vld = 1'b0;
  logic [7:0] issue_tag = 8'd0;
  logic [7:0] issue_op = 8'd0;
  logic ring_rd;
  logic [3:0] ring_addr;
  logic [31:0] ring_data;
  logic done_vld, retry_vld, proto_err;
  logic [7:0] done_tag, retry_tag, retry_op;
  logic [2:0] done_res;
  logic [15:0] cnt_crc, cnt_hard, cnt_soft, cnt_rd_fail, cnt_wr_fail, cnt_dis_fail, cnt_retry;

  always #(CLK_P/2) clk = ~clk;

  cpl_sorter dut_i (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
    .issue_vld(issue_vld), .issue_tag(issue_tag), .issue_op(issue_op),
    .ring_rd(ring_rd), .ring_addr(ring_addr), .ring_data(ring_data),
    .done_vld(done_vld), .done_tag(done_tag), .done_res(done_res),
    .retry_vld(retry_vld), .retry_tag(retry_tag), .retry_op(retry_op),
    .proto_err(proto_err),
    .cnt_crc(cnt_crc), .cnt_hard(cnt_hard), .cnt_soft(cnt_soft),
    .cnt_rd_fail(cnt_rd_fail), .cnt_wr_fail(cnt_wr_fail),
    .cnt_dis_fail(cnt_dis_fail), .cnt_retry(cnt_retry)
  );

  logic [31:0] mem [16];
  logic [31:0] ring_q = 32'd0;
  always @(posedge clk) if (ring_rd) ring_q <= mem[ring_addr];
  assign ring_data = ring_q;

  int total = 0, bad = 0, ev_seen = 0;
  bit ended = 0;
  int qk[$], qt[$], qr[$];
  string qn[$];
  int bidx = 0;
  logic [15:0] bexp = 16'd0;
  int m_crc = 0, m_hard = 0, m_soft = 0, m_rdf = 0, m_wrf = 0, m_disf = 0, m_retry = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (done_vld || retry_vld)) begin
      ev_seen++;
      if (qk.size() == 0) chk("R1", "unexpected strobe", 1, 0);
      else begin
        int k, t, r;
        string n;
        k = qk.pop_front(); t = qt.pop_front(); r = qr.pop_front(); n = qn.pop_front();
        chk(n, "kind(1=done,2=retry)", retry_vld ? 2 : 1, k);
        chk(n, "tag", retry_vld ? int'(retry_tag) : int'(done_tag), t);
        if (k == 1) chk(n, "result", int'(done_res), r);
        else chk(n, "retry opcode", int'(retry_op), 'hE0);
      end
    end
  end

  task automatic classify(input logic [7:0] op, input logic [7:0] st,
                          output int kind, output int res, output string req);
    bit b;
    b = st[0] | st[1];
    kind = 1; res = 0; req = "R3";
    if (op == 8'hC0) begin
      if (b && scrub_en) begin kind = 2; req = "R4"; m_retry++; end
      else if (b || st[3]) begin res = 2; req = "R5"; m_rdf++; end
      else if (st != 0) req = "R5";
    end else if (op == 8'hE0) begin
      if (b) begin res = 2; m_rdf++; end
      if (st != 0) req = "R6";
    end else if (op == 8'h80) begin
      if (st != 0) begin res = 2; req = "R7"; m_wrf++; end
    end else if (op == 8'h70) begin
      if (st != 0) begin res = 2; req = "R7"; m_disf++; end
    end else begin
      req = "R8";
      if (st != 0) res = 1;
    end
    m_crc += int'(st[0]); m_hard += int'(st[1]); m_soft += int'(st[2]);
  endtask

  task automatic issue(input logic [7:0] tg, input logic [7:0] op);
    @(negedge clk);
    issue_vld = 1'b1; issue_tag = tg; issue_op = op;
    @(negedge clk);
    issue_vld = 1'b0;
  endtask

  task automatic post(input logic [7:0] tg, input logic [7:0] op, input logic [7:0] st);
    int k, r;
    string n;
    issue(tg, op);
    classify(op, st, k, r, n);
    qk.push_back(k); qt.push_back(int'(tg)); qr.push_back(r); qn.push_back(n);
    mem[bidx] = {bexp, tg, st};
    bidx = (bidx + 1) % 16;
    bexp = bexp + 16'd1;
  endtask

  task automatic drain;
    while (qk.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "cnt_crc", int'(cnt_crc), m_crc);
    chk("R9", "cnt_hard", int'(cnt_hard), m_hard);
    chk("R9", "cnt_soft", int'(cnt_soft), m_soft);
    chk("R10", "cnt_rd_fail", int'(cnt_rd_fail), m_rdf);
    chk("R10", "cnt_wr_fail", int'(cnt_wr_fail), m_wrf);
    chk("R10", "cnt_dis_fail", int'(cnt_dis_fail), m_disf);
    chk("R10", "cnt_retry", int'(cnt_retry), m_retry);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    for (int i = 0; i < 16; i++) mem[i] = 32'hACAC_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "reset done_vld", int'(done_vld), 0);
    chk("R3", "reset retry_vld", int'(retry_vld), 0);
    chk("R11", "reset proto_err", int'(proto_err), 0);
    chk("R9", "reset cnt_crc", int'(cnt_crc), 0);

    post(8'd1, 8'h80, 8'h00);
    post(8'd2, 8'hC0, 8'h00);
    post(8'd3, 8'h70, 8'h00);
    drain();

    scrub_en = 1'b1;
    post(8'd4, 8'hC0, 8'h01);
    drain();
    post(8'd4, 8'hE0, 8'h01);
    post(8'd5, 8'hC0, 8'h02);
    drain();
    post(8'd6, 8'hE0, 8'h08);
    post(8'd7, 8'hE0, 8'h04);
    drain();

    scrub_en = 1'b0;
    post(8'd7, 8'hC0, 8'h01);
    post(8'd8, 8'hC0, 8'h08);
    post(8'd9, 8'hC0, 8'h04);
    post(8'd10, 8'hC0, 8'h07);
    drain();
    post(8'd11, 8'h80, 8'h04);
    post(8'd12, 8'h70, 8'h08);
    post(8'd13, 8'h80, 8'h30);
    post(8'd14, 8'h55, 8'h02);
    post(8'd15, 8'h55, 8'h00);
    drain();

    // R1: a word with the wrong count is neither accepted nor skipped
    issue(8'd1, 8'h80);
    mem[bidx] = {bexp + 16'd5, 8'd1, 8'h00};
    seen = ev_seen;
    repeat (30) @(negedge clk);
    chk("R1", "strobes on stale count", ev_seen - seen, 0);
    post(8'd1, 8'h80, 8'h08);
    drain();

    // R2: several passes around the ring, batches in flight
    for (int g = 0; g < 8; g++) begin
      for (int j = 0; j < 4; j++)
        post(8'(4 * j + (g % 4)), (j % 2 == 0) ? 8'hC0 : 8'h80, 8'(g + j));
      drain();
    end
    chk("R2", "ring wrapped", int'(bexp > 16'd32), 1);

    // R11: tag already completed, never reissued
    post(8'd2, 8'h80, 8'h00);
    drain();
    mem[bidx] = {bexp, 8'd2, 8'h00};
    seen = ev_seen;
    repeat (10) @(negedge clk);
    chk("R11", "proto_err after stale tag", int'(proto_err), 1);
    chk("R11", "strobes after stale tag", ev_seen - seen, 0);
    issue(8'd3, 8'h80);
    mem[(bidx + 1) % 16] = {bexp + 16'd1, 8'd3, 8'h01};
    mem[bidx] = {bexp, 8'd3, 8'h01};
    repeat (20) @(negedge clk);
    chk("R11", "proto_err sticky", int'(proto_err), 1);
    chk("R11", "no strobe after halt", ev_seen - seen, 0);
    chk("R11", "cnt_crc frozen", int'(cnt_crc), m_crc);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule